// File: doc/BRIEF.md
# Descriptor Ring Fetcher

This block is the front end of a DMA engine. It walks a circular list of 16-byte descriptors kept in host memory, and the list is located only by a 64-bit base address and a size mask. While the list is empty the engine waits on a millisecond poll timer and re-reads the current slot. When the first dword of the slot carries its ownership bit, the engine reads the other three dwords and decodes them. It then either starts a downstream data mover or, for a register-setting descriptor, loads one of two high board-address registers. At the end it writes the first dword back with the ownership bit cleared and the mover's status folded in.

Software sets the re-read period, an enable, a clear that holds the engine in reset, and a strobe that forces an immediate fetch. The block connects to a simple request/acknowledge host memory port that carries one dword per transfer. Each retired descriptor that asked for an interrupt raises a one-cycle completion event that carries its direction.

Top module: `ring_fetch`

## Requirements
- R1: The slot address is base plus a ring offset. The engine reads dwords 0, 1, 2 and 3 of a slot at byte offsets +0, +4, +8 and +12, in that order. After each retired descriptor the offset becomes (offset + 16) AND (mask OR the fixed low ones, which are the MASK_LSB least significant bits), so the ring wraps back to the base.
- R2: Dword 0 bit 31 is the ownership bit. If it reads 0, the engine reads nothing further from that slot and returns to waiting. If it reads 1, the remaining three dwords are fetched.
- R3: For a data descriptor (dword 0 bit 28 = 0), mv_start pulses for exactly one cycle, with no memory request in that cycle. While it is high, mv_dir equals dword 0 bit 30 (1 = toward the host), mv_len equals dword 0 bits 23:0, mv_board equals dword 1, and mv_host equals {dword 3, dword 2}.
- R4: A register-setting descriptor (dword 0 bit 28 = 1) does not start the mover. It loads dword 1 into hi_to when dword 0 bit 30 is 1, and into hi_from otherwise.
- R5: Retirement is one write to slot offset +0. The data written is dword 0 with bit 31 = 0, bits 27:26 = 0, bit 25 = the mover's overflow flag and bit 24 = its end-of-transfer flag; both flags are 0 for a register-setting descriptor. All other bits are unchanged. For a data descriptor the write happens only after mv_done.
- R6: done_evt is high for exactly one cycle, together with the acknowledge of the retirement write, and only when dword 0 bit 29 is 1 and bit 28 is 0. done_dir equals dword 0 bit 30.
- R7: Once a read finds an empty slot, that slot is read again after period × CYC_PER_MS clock cycles, plus a fixed overhead of a few cycles.
- R8: The period register resets to 1. A write of 0 stores 1.
- R9: A poll_now pulse while the engine is waiting starts a fetch in the next cycle, without waiting for the timer.
- R10: While cfg_clear is high, no memory request and no mover start occur, and poll_now has no effect. After clear is released, the next fetch reads the slot at the base address.
- R11: While cfg_enable is low, and out of reset, the engine issues no memory requests, even on poll_now.
- R12: After a retirement the engine reads the next slot at once, without waiting for the timer.
- R13: A memory request keeps mem_req, mem_we and mem_addr stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW | Ring base address, low 12 bits zero |
| cfg_mask | input | OFS_W | Ring size in bytes minus one |
| cfg_enable | input | 1 | Engine enable |
| cfg_clear | input | 1 | Hold engine in reset, pointer back to base |
| per_we | input | 1 | Write strobe for the poll period |
| per_wdata | input | PER_W | Poll period in milliseconds |
| poll_now | input | 1 | Fetch the current slot immediately |
| mem_req | output | 1 | Host memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Dword byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | Start pulse to the data mover |
| mv_dir | output | 1 | 1 = toward host |
| mv_len | output | 24 | Length in dwords |
| mv_board | output | 32 | Board dword address |
| mv_host | output | 64 | Host physical address |
| mv_done | input | 1 | Mover finished |
| mv_ovf | input | 1 | Mover saw more data than expected |
| mv_eot | input | 1 | Mover saw end of transfer |
| hi_to | output | 32 | High board address, toward-host direction |
| hi_from | output | 32 | High board address, from-host direction |
| done_evt | output | 1 | Completion event pulse |
| done_dir | output | 1 | Direction of the completed descriptor |

## Verification
Several properties are checked on every cycle: requests are held until acknowledged, every retirement write clears the ownership bit and the reserved bits, the mover start is a lone pulse that never overlaps a memory request, completion events coincide with a retirement acknowledge, and a clear silences the memory and mover ports. The remaining behaviours need the bench's scenarios. These are the order and addresses of the fetches, wrapping through a four-slot ring, the decoded field values, the routing of register-setting descriptors, the poll interval for several period writes including zero, and the return to the base slot after a clear.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int DWORD_W    = 32;
    localparam int DESC_BYTES = 16;
    localparam int LEN_W      = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_MOVE,
        ST_WBACK
    } seq_state_e;

    // Layout of descriptor dword 0; the bit positions are shared with host software.
    typedef struct packed {
        logic             owned;
        logic             to_host;
        logic             irq;
        logic             setreg;
        logic [1:0]       rsvd;
        logic             ovf;
        logic             eot;
        logic [LEN_W-1:0] len;
    } head_word_t;

    function automatic head_word_t retire_word(head_word_t d, logic ovf, logic eot);
        head_word_t r;
        r       = d;
        r.owned = 1'b0;
        r.rsvd  = 2'b00;
        r.ovf   = ovf;
        r.eot   = eot;
        return r;
    endfunction

endpackage

// File: rtl/ring_tick.sv
module ring_tick #(
    parameter int CYC_PER_MS = 100000,
    parameter int PER_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             per_we,
    input  logic [PER_W-1:0] per_wdata,
    output logic             expire
);
    localparam int CNT_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(CYC_PER_MS - 1);
    localparam logic [PER_W-1:0] PER_ONE  = PER_W'(1);

    logic [CNT_W-1:0] pre_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] wait_q;
    logic             tick;

    assign tick   = (pre_q == PRE_LAST) && !arm;
    assign expire = tick && (wait_q == PER_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= PER_ONE;
        end else if (per_we) begin
            per_q <= (per_wdata == '0) ? PER_ONE : per_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (arm) begin
            wait_q <= per_q;
        end else if (tick && wait_q != '0) begin
            wait_q <= wait_q - PER_ONE;
        end
    end

endmodule

// File: rtl/ring_ptr.sv
module ring_ptr #(
    parameter int AW       = 64,
    parameter int OFS_W    = 20,
    parameter int MASK_LSB = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [AW-1:0]    base,
    input  logic [OFS_W-1:0] mask,
    output logic [AW-1:0]    slot_addr
);
    import ring_pkg::*;

    localparam logic [OFS_W-1:0] LOW_ONES = OFS_W'((64'd1 << MASK_LSB) - 64'd1);
    localparam logic [OFS_W-1:0] STEP     = OFS_W'(DESC_BYTES);

    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] eff_mask;

    assign eff_mask  = mask | LOW_ONES;
    assign slot_addr = base + AW'(ofs_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
        end else if (advance) begin
            ofs_q <= (ofs_q + STEP) & eff_mask;
        end
    end

endmodule

// File: rtl/ring_seq.sv
module ring_seq #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          poll_now,
    input  logic          expire,
    output logic          arm,
    output logic          advance,
    input  logic [AW-1:0] slot_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          mv_start,
    output logic          mv_dir,
    output logic [23:0]   mv_len,
    output logic [31:0]   mv_board,
    output logic [63:0]   mv_host,
    input  logic          mv_done,
    input  logic          mv_ovf,
    input  logic          mv_eot,
    output logic [31:0]   hi_to,
    output logic [31:0]   hi_from,
    output logic          done_evt,
    output logic          done_dir
);
    import ring_pkg::*;

    seq_state_e  state;
    logic [1:0]  idx;
    logic [31:0] dw_q [4];
    logic        ovf_q, eot_q, start_q;
    logic [31:0] hi_to_q, hi_from_q;
    head_word_t  head;
    logic        rd_hit, empty_hit;

    assign head      = head_word_t'(dw_q[0]);
    assign rd_hit    = (state == ST_READ) && mem_ack;
    assign empty_hit = rd_hit && (idx == 2'd0) && !mem_rdata[31];

    assign mem_req   = (state == ST_READ) || (state == ST_WBACK);
    assign mem_we    = (state == ST_WBACK);
    assign mem_addr  = mem_we ? slot_addr : slot_addr + AW'({idx, 2'b00});
    assign mem_wdata = retire_word(head, ovf_q, eot_q);

    assign arm       = ((state == ST_IDLE) && enable) || empty_hit;
    assign advance   = (state == ST_WBACK) && mem_ack;
    assign done_evt  = advance && head.irq && !head.setreg;
    assign done_dir  = head.to_host;

    assign mv_start  = start_q;
    assign mv_dir    = head.to_host;
    assign mv_len    = head.len;
    assign mv_board  = dw_q[1];
    assign mv_host   = {dw_q[3], dw_q[2]};
    assign hi_to     = hi_to_q;
    assign hi_from   = hi_from_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx       <= 2'd0;
            for (int i = 0; i < 4; i++) dw_q[i] <= '0;
            ovf_q     <= 1'b0;
            eot_q     <= 1'b0;
            start_q   <= 1'b0;
            hi_to_q   <= '0;
            hi_from_q <= '0;
        end else begin
            start_q <= 1'b0;
            case (state)
                ST_IDLE: if (enable) state <= ST_WAIT;
                ST_WAIT: begin
                    if (!enable) begin
                        state <= ST_IDLE;
                    end else if (poll_now || expire) begin
                        state <= ST_READ;
                        idx   <= 2'd0;
                    end
                end
                ST_READ: if (mem_ack) begin
                    dw_q[idx] <= mem_rdata;
                    if (idx == 2'd0) begin
                        ovf_q <= 1'b0;
                        eot_q <= 1'b0;
                    end
                    if (empty_hit) begin
                        state <= ST_WAIT;
                    end else if (idx == 2'd3) begin
                        if (head.setreg) begin
                            if (head.to_host) hi_to_q   <= dw_q[1];
                            else              hi_from_q <= dw_q[1];
                            state <= ST_WBACK;
                        end else begin
                            start_q <= 1'b1;
                            state   <= ST_MOVE;
                        end
                    end else begin
                        idx <= idx + 2'd1;
                    end
                end
                ST_MOVE: if (mv_done) begin
                    ovf_q <= mv_ovf;
                    eot_q <= mv_eot;
                    state <= ST_WBACK;
                end
                ST_WBACK: if (mem_ack) begin
                    idx   <= 2'd0;
                    state <= enable ? ST_READ : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ring_fetch.sv
module ring_fetch #(
    parameter int AW         = 64,
    parameter int OFS_W      = 20,
    parameter int MASK_LSB   = 12,
    parameter int PER_W      = 10,
    parameter int CYC_PER_MS = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    cfg_base,
    input  logic [OFS_W-1:0] cfg_mask,
    input  logic             cfg_enable,
    input  logic             cfg_clear,
    input  logic             per_we,
    input  logic [PER_W-1:0] per_wdata,
    input  logic             poll_now,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             mv_start,
    output logic             mv_dir,
    output logic [23:0]      mv_len,
    output logic [31:0]      mv_board,
    output logic [63:0]      mv_host,
    input  logic             mv_done,
    input  logic             mv_ovf,
    input  logic             mv_eot,
    output logic [31:0]      hi_to,
    output logic [31:0]      hi_from,
    output logic             done_evt,
    output logic             done_dir
);
    logic          eng_rst;
    logic          arm, expire, advance;
    logic [AW-1:0] slot_addr;

    assign eng_rst = rst || cfg_clear;

    ring_tick #(.CYC_PER_MS(CYC_PER_MS), .PER_W(PER_W)) u_tick (
        .clk(clk), .rst(rst), .arm(arm), .per_we(per_we),
        .per_wdata(per_wdata), .expire(expire)
    );

    ring_ptr #(.AW(AW), .OFS_W(OFS_W), .MASK_LSB(MASK_LSB)) u_ptr (
        .clk(clk), .rst(eng_rst), .advance(advance), .base(cfg_base),
        .mask(cfg_mask), .slot_addr(slot_addr)
    );

    ring_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(eng_rst), .enable(cfg_enable), .poll_now(poll_now),
        .expire(expire), .arm(arm), .advance(advance), .slot_addr(slot_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_start(mv_start), .mv_dir(mv_dir), .mv_len(mv_len),
        .mv_board(mv_board), .mv_host(mv_host), .mv_done(mv_done),
        .mv_ovf(mv_ovf), .mv_eot(mv_eot), .hi_to(hi_to), .hi_from(hi_from),
        .done_evt(done_evt), .done_dir(done_dir)
    );

endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_clear,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          mv_start,
    input logic          done_evt
);
    // R13: a pending request holds its command and address
    p_req_hold_r13: assert property (@(posedge clk) disable iff (rst || cfg_clear)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: every retirement write hands ownership back and zeroes the reserved field
    p_wb_release_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (!mem_wdata[31] && mem_wdata[27:26] == 2'b00));

    // R3: the mover start is a lone pulse
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> !mv_start);

    // R3: no memory traffic in the start cycle
    p_start_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        mv_start |-> !mem_req);

    // R6: completion event only together with an acknowledged retirement write
    p_evt_on_wb_r6: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> (mem_req && mem_we && mem_ack));

    // R6: completion event lasts one cycle
    p_evt_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !done_evt);

    // R10: clear silences memory and mover ports
    p_clear_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_clear |=> (!mem_req && !mv_start));

endmodule

bind ring_fetch ring_fetch_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_ring_fetch.sv
module test_ring_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 10;
    localparam int SLOTS      = 4;
    localparam logic [63:0] BASE = 64'h0000_0001_0000_2000;

    logic        clk, rst;
    logic [63:0] cfg_base;
    logic [19:0] cfg_mask;
    logic        cfg_enable, cfg_clear, per_we, poll_now;
    logic [9:0]  per_wdata;
    logic        mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mv_start, mv_dir, mv_done, mv_ovf, mv_eot;
    logic [23:0] mv_len;
    logic [31:0] mv_board, hi_to, hi_from;
    logic [63:0] mv_host;
    logic        done_evt, done_dir;

    ring_fetch #(.OFS_W(20), .MASK_LSB(6), .PER_W(10), .CYC_PER_MS(CYC)) i_ring_fetch (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_enable(cfg_enable), .cfg_clear(cfg_clear), .per_we(per_we),
        .per_wdata(per_wdata), .poll_now(poll_now), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mv_start(mv_start),
        .mv_dir(mv_dir), .mv_len(mv_len), .mv_board(mv_board), .mv_host(mv_host),
        .mv_done(mv_done), .mv_ovf(mv_ovf), .mv_eot(mv_eot), .hi_to(hi_to),
        .hi_from(hi_from), .done_evt(done_evt), .done_dir(done_dir)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // host memory model, two-cycle acknowledge
    logic [31:0] mem [logic [63:0]];
    logic [1:0]  lat;
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            lat     <= 2'd0;
        end else if (mem_req && !mem_ack) begin
            if (lat == 2'd1) begin
                mem_ack   <= 1'b1;
                lat       <= 2'd0;
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                if (mem_we) mem[mem_addr] = mem_wdata;
            end else begin
                lat <= lat + 2'd1;
            end
        end else begin
            mem_ack <= 1'b0;
            lat     <= 2'd0;
        end
    end

    // scoreboard
    typedef struct packed {
        logic        we;
        logic [63:0] addr;
        logic [31:0] data;
    } txn_t;
    txn_t  exp_q[$];
    string tag_q[$];
    bit    sb_on = 0;
    int    req_cnt = 0, start_cnt = 0, evt_cnt = 0;
    logic  last_dir = 1'b0;
    int    rise_q[$];
    logic  prev_req = 1'b0;

    task automatic push(input logic we, input logic [63:0] a, input logic [31:0] d, input string tag);
        txn_t t;
        t.we = we; t.addr = a; t.data = d;
        exp_q.push_back(t);
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) req_cnt++;
            if (mv_start) start_cnt++;
            if (done_evt) begin
                evt_cnt++;
                last_dir = done_dir;
            end
            if (mem_req && !prev_req && !sb_on) rise_q.push_back(cyc);
            if (mem_req && mem_ack && sb_on) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected transfer", mem_addr, 64'h0);
                end else begin
                    txn_t  e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(e.we == mem_we && e.addr == mem_addr, tg, {mem_we, mem_addr[62:0]}, {e.we, e.addr[62:0]});
                    if (e.we) chk(e.data == mem_wdata, "R5 writeback data", {32'h0, mem_wdata}, {32'h0, e.data});
                end
            end
        end
        prev_req = mem_req;
    end

    task automatic pulse_poll();
        @(negedge clk) poll_now = 1'b1;
        @(negedge clk) poll_now = 1'b0;
    endtask

    task automatic wait_q_empty(input string tag);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'h0);
    endtask

    task automatic measure_gap(input int per, input string tag);
        int n;
        int gap;
        rise_q.delete();
        n = 0;
        while (rise_q.size() < 3 && n < 200 * per + 200) begin
            @(negedge clk);
            n++;
        end
        gap = (rise_q.size() >= 3) ? rise_q[2] - rise_q[1] : 0;
        chk(gap >= per * CYC + 1 && gap <= per * CYC + 5, tag, 64'(gap), 64'(per * CYC + 3));
    endtask

    // R1 R2 R3 R4 R5 R6 R9 R12: fetch one slot and retire it
    task automatic run_slot(input int slot, input logic [31:0] d0, input logic [31:0] d1,
                            input logic [63:0] host, input logic ovf, input logic eot);
        logic [63:0] a, nxt;
        logic [31:0] wb;
        int          s0, e0, n;
        bit          setreg;
        setreg = d0[28];
        a   = BASE + 64'(slot * 16);
        nxt = BASE + 64'(((slot + 1) % SLOTS) * 16);
        mem[a] = d0; mem[a + 4] = d1; mem[a + 8] = host[31:0]; mem[a + 12] = host[63:32];
        wb = {1'b0, d0[30:28], 2'b00, setreg ? 2'b00 : {ovf, eot}, d0[23:0]};
        push(1'b0, a,      32'h0, "R1 dword0 read");
        push(1'b0, a + 4,  32'h0, "R2 dword1 read");
        push(1'b0, a + 8,  32'h0, "R1 dword2 read");
        push(1'b0, a + 12, 32'h0, "R1 dword3 read");
        push(1'b1, a,      wb,    "R5 retirement write");
        push(1'b0, nxt,    32'h0, "R12 next slot read");
        s0 = start_cnt;
        e0 = evt_cnt;
        @(negedge clk) poll_now = 1'b1;
        @(negedge clk) poll_now = 1'b0;
        chk(mem_req == 1'b1, "R9 poll_now starts fetch", 64'(mem_req), 64'h1);
        if (!setreg) begin
            n = 0;
            while (!mv_start && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(mv_start == 1'b1, "R3 mover start", 64'(mv_start), 64'h1);
            chk(mv_dir == d0[30] && mv_len == d0[23:0], "R3 dir/len",
                {39'h0, mv_dir, mv_len}, {39'h0, d0[30], d0[23:0]});
            chk(mv_board == d1, "R3 board address", 64'(mv_board), 64'(d1));
            chk(mv_host == host, "R3 host address", mv_host, host);
            @(negedge clk);
            @(negedge clk);
            mv_done = 1'b1; mv_ovf = ovf; mv_eot = eot;
            @(negedge clk);
            mv_done = 1'b0; mv_ovf = 1'b0; mv_eot = 1'b0;
        end
        wait_q_empty("R12 slot sequence complete");
        repeat (3) @(negedge clk);
        if (setreg) begin
            chk(start_cnt == s0, "R4 no mover start", 64'(start_cnt - s0), 64'h0);
            if (d0[30]) chk(hi_to == d1, "R4 hi_to load", 64'(hi_to), 64'(d1));
            else        chk(hi_from == d1, "R4 hi_from load", 64'(hi_from), 64'(d1));
        end
        chk(evt_cnt - e0 == ((d0[29] && !setreg) ? 1 : 0), "R6 completion event count",
            64'(evt_cnt - e0), 64'((d0[29] && !setreg) ? 1 : 0));
        if (d0[29] && !setreg) chk(last_dir == d0[30], "R6 completion direction", 64'(last_dir), 64'(d0[30]));
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 64'h0, 64'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int r0;
        rst = 1'b1; cfg_base = BASE; cfg_mask = 20'h3F; cfg_enable = 1'b0; cfg_clear = 1'b0;
        per_we = 1'b0; per_wdata = '0; poll_now = 1'b0; mv_done = 1'b0; mv_ovf = 1'b0; mv_eot = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_req == 1'b0 && mv_start == 1'b0 && done_evt == 1'b0, "R11 reset state quiet",
            {61'h0, mem_req, mv_start, done_evt}, 64'h0);
        chk(hi_to == 32'h0 && hi_from == 32'h0, "R4 reset high registers", {hi_to, hi_from}, 64'h0);

        // R11: disabled engine ignores poll_now
        r0 = req_cnt;
        pulse_poll();
        repeat (20) @(negedge clk);
        chk(req_cnt == r0, "R11 disabled no requests", 64'(req_cnt - r0), 64'h0);

        // R8 R7: poll interval
        cfg_enable = 1'b1;
        repeat (3) @(negedge clk);
        pulse_poll();
        measure_gap(1, "R8 default period is 1");
        @(negedge clk) begin per_we = 1'b1; per_wdata = 10'd0; end
        @(negedge clk) per_we = 1'b0;
        measure_gap(1, "R8 write of zero stores 1");
        @(negedge clk) begin per_we = 1'b1; per_wdata = 10'd3; end
        @(negedge clk) per_we = 1'b0;
        measure_gap(3, "R7 period 3 interval");
        @(negedge clk) begin per_we = 1'b1; per_wdata = 10'd1000; end
        @(negedge clk) per_we = 1'b0;
        repeat (50) @(negedge clk);
        while (mem_req) @(negedge clk);
        repeat (3) @(negedge clk);
        sb_on = 1;

        // data descriptors
        run_slot(0, 32'hE000_0010, 32'h0000_4000, 64'h0000_0002_1234_5670, 1'b0, 1'b1);
        run_slot(1, 32'h8000_0003, 32'h0000_8888, 64'h0000_0000_0ABC_0000, 1'b1, 1'b0);

        // R10: clear returns the ring to the base slot
        cfg_clear = 1'b1;
        pulse_poll();
        repeat (4) @(negedge clk);
        chk(mem_req == 1'b0 && mv_start == 1'b0, "R10 clear holds engine",
            {62'h0, mem_req, mv_start}, 64'h0);
        cfg_clear = 1'b0;
        repeat (3) @(negedge clk);
        push(1'b0, BASE, 32'h0, "R10 fetch at base after clear");
        pulse_poll();
        wait_q_empty("R10 base fetch done");
        repeat (3) @(negedge clk);

        // register-setting descriptors, then data through the wrap
        run_slot(0, 32'hF000_0000, 32'hABCD_1234, 64'h0, 1'b0, 1'b0);
        run_slot(1, 32'h9000_0000, 32'h5555_AAAA, 64'h0, 1'b0, 1'b0);
        chk(hi_to == 32'hABCD_1234, "R4 hi_to kept", 64'(hi_to), 64'hABCD_1234);
        run_slot(2, 32'hA000_0100, 32'h0000_0040, 64'h0000_0000_8000_0000, 1'b1, 1'b1);
        run_slot(3, 32'hE000_0001, 32'h0000_0010, 64'h0000_0003_0000_0010, 1'b0, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule